// File: doc/BRIEF.md
# Overlapping register window file

This block is a register file of 32-bit words that presents 32 logical registers to the code running in the current procedure. It maps them onto a larger physical bank through a window pointer. Logical registers 0 to 9 are shared by every window, and register 0 always reads as zero. Logical registers 10 to 31 are remapped per window. A window's outgoing group (10 to 15) and its private locals (16 to 25) are its own physical registers. Its incoming group (26 to 31) is the outgoing group of the window above it. Arguments therefore pass from caller to callee without any copy.

A call steps the window pointer down by one and a return steps it back up, both modulo eight windows. A count of resident windows tracks nesting depth. The block raises a one-cycle overflow flag when a call arrives with seven windows already nested. It raises a one-cycle underflow flag when a return arrives with none saved. Saving and restoring windows to memory is left to whatever watches these flags. The block offers two combinational read ports and one write port that takes effect at the clock edge.

Top module: `rwin_file`

## Requirements
- R1: After reset the window pointer is 0, the depth count is 0, both flags are low, and every logical register reads zero.
- R2: Logical register 0 reads zero in every window, and a write to it has no effect.
- R3: Logical registers 1 to 9 are global: a value written in one window reads back unchanged from any other window.
- R4: Logical registers 16 to 25 are private to a window: a callee sees its own locals, not the caller's, and the caller's locals are intact after the return.
- R5: A call alone (callEn=1, retEn=0) moves the window pointer from w to w-1 modulo 8 (0 goes to 7) and raises the depth count by one, holding it at 7.
- R6: A return alone (retEn=1, callEn=0) moves the window pointer from w to w+1 modulo 8 (7 goes to 0) and lowers the depth count by one, holding it at 0.
- R7: After a call, the callee's logical register k+16 is the caller's register k for k from 10 to 15, in both directions and with no copy.
- R8: A call made while the depth count is 7 drives ovfFlag high for exactly the next cycle. The pointer still moves and the depth stays 7.
- R9: A return made while the depth count is 0 drives unfFlag high for exactly the next cycle. The pointer still moves and the depth stays 0.
- R10: When callEn and retEn are both high in one cycle, the pointer, the depth and both flags are left as if neither had been requested.
- R11: A write in the same cycle as a call or a return lands in the window selected before the pointer moves.
- R12: The read ports are combinational on address and pointer. A write shows on the read ports from the cycle after its clock edge, and a read of the same register in the write cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| callEn | input | 1 | Procedure call: step the window down |
| retEn | input | 1 | Procedure return: step the window up |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 5 | Logical register written |
| wrData | input | 32 | Write data |
| rdAddrA | input | 5 | Logical register for read port A |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 5 | Logical register for read port B |
| rdDataB | output | 32 | Read port B data |
| winPtr | output | 3 | Current window pointer |
| winDepth | output | 3 | Count of nested resident windows |
| ovfFlag | output | 1 | One-cycle pulse: call at full depth |
| unfFlag | output | 1 | One-cycle pulse: return at zero depth |

## Verification
The hardest state to reach from the ports is the wrap of the pointer past window 0 with a full depth count. Only seven unbroken calls get there, and the eighth call must then overflow while the freshly reused window still holds the data of the outermost procedure. A directed chain of eight calls drives the block into that state. A fixed-seed random walk of calls, returns and writes then keeps hitting both depth limits and the pointer wrap. Every read port is compared each cycle against a bench model of globals and per-window groups. Directed cycles cover the write that coincides with a call, the call and return that collide, and the overlap in both directions.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  // Window geometry
  parameter int unsigned RW_GLOBALS = 10;
  parameter int unsigned RW_OVL     = 6;
  parameter int unsigned RW_LOCALS  = 10;
  parameter int unsigned RW_WINDOWS = 8;

  localparam int unsigned RW_LOGICAL   = RW_GLOBALS + 2 * RW_OVL + RW_LOCALS;
  localparam int unsigned RW_ADDR_W    = $clog2(RW_LOGICAL);
  localparam int unsigned RW_WIN_NEW   = RW_OVL + RW_LOCALS;
  localparam int unsigned RW_HIGH_BASE = RW_LOGICAL - RW_OVL;
  localparam int unsigned RW_PHYS      = RW_GLOBALS + RW_WINDOWS * RW_WIN_NEW;
  localparam int unsigned RW_PHYS_W    = $clog2(RW_PHYS);
  localparam int unsigned RW_WP_W      = $clog2(RW_WINDOWS);
  localparam int unsigned RW_MAX_DEPTH = RW_WINDOWS - 1;
  localparam int unsigned RW_NUM_PORTS = 3;

  typedef logic [RW_ADDR_W-1:0] logIdx_t;
  typedef logic [RW_PHYS_W-1:0] physIdx_t;
  typedef logic [RW_WP_W-1:0]   winPtr_t;

  // Strobes from control to the storage datapath
  typedef struct packed {
    logic     wrStb;
    physIdx_t wrIdx;
    physIdx_t rdIdxA;
    physIdx_t rdIdxB;
  } bankCtl_t;
endpackage

// File: rtl/rwin_map.sv
module rwin_map
  import rwin_pkg::*;
(
  input  winPtr_t  win,
  input  logIdx_t  logIdx,
  output physIdx_t physIdx
);
  localparam winPtr_t LAST_WIN = winPtr_t'(RW_WINDOWS - 1);

  always_comb begin
    int unsigned k;
    int unsigned upper;
    int unsigned p;
    k     = 32'(logIdx);
    // the incoming group belongs to the window one step up
    upper = (win == LAST_WIN) ? 0 : 32'(win) + 1;
    if (k < RW_GLOBALS) begin
      p = k;
    end else if (k < RW_HIGH_BASE) begin
      p = RW_GLOBALS + RW_WIN_NEW * 32'(win) + (k - RW_GLOBALS);
    end else begin
      p = RW_GLOBALS + RW_WIN_NEW * upper + (k - RW_HIGH_BASE);
    end
    physIdx = RW_PHYS_W'(p);
  end
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     callEn,
  input  logic     retEn,
  input  logic     wrEn,
  input  logIdx_t  wrAddr,
  input  logIdx_t  rdAddrA,
  input  logIdx_t  rdAddrB,
  output bankCtl_t bankCtl,
  output winPtr_t  winPtr,
  output winPtr_t  winDepth,
  output logic     ovfFlag,
  output logic     unfFlag
);
  localparam winPtr_t LAST_WIN  = winPtr_t'(RW_WINDOWS - 1);
  localparam winPtr_t MAX_DEPTH = winPtr_t'(RW_MAX_DEPTH);

  winPtr_t  cwp;
  winPtr_t  depth;
  winPtr_t  cwpDown;
  winPtr_t  cwpUp;
  logic     doCall;
  logic     doRet;
  logIdx_t  mapIn  [RW_NUM_PORTS];
  physIdx_t mapOut [RW_NUM_PORTS];

  assign mapIn[0] = wrAddr;
  assign mapIn[1] = rdAddrA;
  assign mapIn[2] = rdAddrB;

  // one mapper per port, all on the pre-update pointer
  for (genvar g = 0; g < RW_NUM_PORTS; g++) begin : g_map
    rwin_map u_map (
      .win    (cwp),
      .logIdx (mapIn[g]),
      .physIdx(mapOut[g])
    );
  end

  always_comb begin
    doCall  = callEn && !retEn;
    doRet   = retEn && !callEn;
    cwpDown = (cwp == '0) ? LAST_WIN : cwp - 1'b1;
    cwpUp   = (cwp == LAST_WIN) ? '0 : cwp + 1'b1;
    bankCtl.wrStb  = wrEn && (wrAddr != '0);
    bankCtl.wrIdx  = mapOut[0];
    bankCtl.rdIdxA = mapOut[1];
    bankCtl.rdIdxB = mapOut[2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cwp     <= '0;
      depth   <= '0;
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else begin
      ovfFlag <= doCall && (depth == MAX_DEPTH);
      unfFlag <= doRet && (depth == '0);
      if (doCall) begin
        cwp <= cwpDown;
        if (depth != MAX_DEPTH) depth <= depth + 1'b1;
      end else if (doRet) begin
        cwp <= cwpUp;
        if (depth != '0) depth <= depth - 1'b1;
      end
    end
  end

  assign winPtr   = cwp;
  assign winDepth = depth;

  a_r5_call_steps_down: assert property (@(posedge clk) disable iff (!rstN)
    (callEn && !retEn) |=> (cwp == (($past(cwp) == '0) ? LAST_WIN : $past(cwp) - 1'b1)));

  a_r6_ret_steps_up: assert property (@(posedge clk) disable iff (!rstN)
    (retEn && !callEn) |=> (cwp == (($past(cwp) == LAST_WIN) ? winPtr_t'(0) : $past(cwp) + 1'b1)));

  a_r8_overflow_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (callEn && !retEn && depth == MAX_DEPTH) |=> (ovfFlag && depth == MAX_DEPTH));

  a_r9_underflow_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (retEn && !callEn && depth == '0) |=> (unfFlag && depth == '0));

  a_r10_collision_hold: assert property (@(posedge clk) disable iff (!rstN)
    (callEn && retEn) |=> ($stable(cwp) && $stable(depth) && !ovfFlag && !unfFlag));
endmodule

// File: rtl/rwin_bank.sv
module rwin_bank
  import rwin_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankCtl_t          bankCtl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  logic [DATA_W-1:0] regs [RW_PHYS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < int'(RW_PHYS); i++) regs[i] <= '0;
    end else if (bankCtl.wrStb) begin
      regs[bankCtl.wrIdx] <= wrData;
    end
  end

  // physical slot 0 is the hardwired zero register
  always_comb begin
    rdDataA = (bankCtl.rdIdxA == '0) ? '0 : regs[bankCtl.rdIdxA];
    rdDataB = (bankCtl.rdIdxB == '0) ? '0 : regs[bankCtl.rdIdxB];
  end

  a_r2_no_zero_write: assert property (@(posedge clk) disable iff (!rstN)
    bankCtl.wrStb |-> (bankCtl.wrIdx != '0));

  a_r3_write_in_range: assert property (@(posedge clk) disable iff (!rstN)
    bankCtl.wrStb |-> (32'(bankCtl.wrIdx) < RW_PHYS));
endmodule

// File: rtl/rwin_file.sv
module rwin_file
  import rwin_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 callEn,
  input  logic                 retEn,
  input  logic                 wrEn,
  input  logic [RW_ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [RW_ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0]    rdDataA,
  input  logic [RW_ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0]    rdDataB,
  output logic [RW_WP_W-1:0]   winPtr,
  output logic [RW_WP_W-1:0]   winDepth,
  output logic                 ovfFlag,
  output logic                 unfFlag
);
  bankCtl_t bankCtl;

  rwin_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .callEn  (callEn),
    .retEn   (retEn),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .bankCtl (bankCtl),
    .winPtr  (winPtr),
    .winDepth(winDepth),
    .ovfFlag (ovfFlag),
    .unfFlag (unfFlag)
  );

  rwin_bank #(.DATA_W(DATA_W)) u_bank (
    .clk    (clk),
    .rstN   (rstN),
    .bankCtl(bankCtl),
    .wrData (wrData),
    .rdDataA(rdDataA),
    .rdDataB(rdDataB)
  );
endmodule

// File: tb/tb_rwin_file.sv
`timescale 1ns/1ps
module tb_rwin_file;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        callEn = 1'b0, retEn = 1'b0, wrEn = 1'b0;
  logic [4:0]  wrAddr = '0, rdAddrA = '0, rdAddrB = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdDataA, rdDataB;
  logic [2:0]  winPtr, winDepth;
  logic        ovfFlag, unfFlag;

  int nChecks = 0;
  int nFail = 0;

  // bench model: globals plus per-window outgoing+local groups
  logic [31:0] mGlob [10];
  logic [31:0] mWin  [8][16];
  int          mPtr = 0;
  int          mDepth = 0;
  logic        expOvf = 1'b0, expUnf = 1'b0;

  always #5 clk = ~clk;

  rwin_file dut (
    .clk(clk), .rstN(rstN), .callEn(callEn), .retEn(retEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .winPtr(winPtr), .winDepth(winDepth),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  function automatic logic [31:0] modelRead(int k);
    if (k == 0) return 32'h0;
    if (k < 10) return mGlob[k];
    if (k < 26) return mWin[mPtr][k - 10];
    return mWin[(mPtr + 1) % 8][k - 26];
  endfunction

  function automatic void modelWrite(int k, logic [31:0] d);
    if (k == 0) return;
    if (k < 10) mGlob[k] = d;
    else if (k < 26) mWin[mPtr][k - 10] = d;
    else mWin[(mPtr + 1) % 8][k - 26] = d;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Starts just after a falling edge; ends at the next falling edge.
  task automatic cycle(input logic c, input logic r, input logic we,
                       input int wa, input logic [31:0] wd,
                       input int ra, input int rb, input string tag);
    callEn = c; retEn = r; wrEn = we;
    wrAddr = 5'(wa); wrData = wd; rdAddrA = 5'(ra); rdAddrB = 5'(rb);
    #1;
    chk(tag, "rdDataA", rdDataA, modelRead(ra));
    chk(tag, "rdDataB", rdDataB, modelRead(rb));
    @(posedge clk);
    if (we) modelWrite(wa, wd);
    expOvf = 1'b0; expUnf = 1'b0;
    if (c && !r) begin
      expOvf = (mDepth == 7);
      mPtr = (mPtr + 7) % 8;
      if (mDepth < 7) mDepth++;
    end else if (r && !c) begin
      expUnf = (mDepth == 0);
      mPtr = (mPtr + 1) % 8;
      if (mDepth > 0) mDepth--;
    end
    @(negedge clk);
    chk(tag, "winPtr", 32'(winPtr), 32'(mPtr));
    chk(tag, "winDepth", 32'(winDepth), 32'(mDepth));
    chk(tag, "ovfFlag", 32'(ovfFlag), 32'(expOvf));
    chk(tag, "unfFlag", 32'(unfFlag), 32'(expUnf));
    callEn = 1'b0; retEn = 1'b0; wrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 10; i++) mGlob[i] = '0;
    for (int w = 0; w < 8; w++)
      for (int j = 0; j < 16; j++) mWin[w][j] = '0;
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, every register in window 0
    chk("R1", "winPtr", 32'(winPtr), 32'd0);
    chk("R1", "winDepth", 32'(winDepth), 32'd0);
    chk("R1", "flags", 32'({ovfFlag, unfFlag}), 32'd0);
    for (int k = 0; k < 32; k++) cycle(0, 0, 0, 0, 0, k, 31 - k, "R1");

    // R2: register 0 ignores writes
    cycle(0, 0, 1, 0, 32'hDEAD_BEEF, 0, 0, "R2");
    cycle(0, 0, 0, 0, 0, 0, 0, "R2");

    // R12: same-cycle read sees the old value, next cycle the new one
    cycle(0, 0, 1, 18, 32'h1234_5678, 18, 18, "R12");
    cycle(0, 0, 0, 0, 0, 18, 0, "R12");

    // R3: globals across windows
    cycle(0, 0, 1, 5, 32'h1111_0005, 5, 9, "R3");
    cycle(1, 0, 0, 0, 0, 5, 0, "R5");
    cycle(0, 0, 1, 9, 32'h9999_0009, 5, 9, "R3");
    cycle(0, 1, 0, 0, 0, 9, 5, "R6");
    cycle(0, 0, 0, 0, 0, 9, 5, "R3");

    // R7: outgoing group becomes callee's incoming group, both ways
    cycle(0, 0, 1, 12, 32'hA0A0_0012, 0, 0, "R7");
    cycle(0, 0, 1, 15, 32'hB0B0_0015, 0, 0, "R7");
    cycle(1, 0, 0, 0, 0, 12, 15, "R5");
    cycle(0, 0, 1, 26, 32'hC0C0_0026, 28, 31, "R7");
    cycle(0, 1, 0, 0, 0, 26, 28, "R6");
    cycle(0, 0, 0, 0, 0, 10, 12, "R7");

    // R4: locals private per window
    cycle(0, 0, 1, 20, 32'h4444_0020, 0, 0, "R4");
    cycle(1, 0, 0, 0, 0, 20, 0, "R4");
    cycle(0, 0, 1, 20, 32'h7777_0020, 20, 18, "R4");
    cycle(0, 1, 0, 0, 0, 20, 0, "R4");
    cycle(0, 0, 0, 0, 0, 20, 18, "R4");

    // R11: write coinciding with call/return uses the old window
    cycle(1, 0, 1, 13, 32'h1313_0013, 0, 0, "R11");
    cycle(0, 0, 0, 0, 0, 29, 13, "R11");
    cycle(0, 1, 1, 27, 32'h2727_0027, 0, 0, "R11");
    cycle(0, 0, 0, 0, 0, 11, 13, "R11");

    // R10: call and return together
    cycle(1, 1, 0, 0, 0, 0, 0, "R10");
    cycle(0, 0, 0, 0, 0, 0, 0, "R10");

    // R9: return at depth 0 wraps pointer upward and flags underflow
    cycle(0, 1, 0, 0, 0, 0, 0, "R9");
    cycle(0, 0, 0, 0, 0, 20, 28, "R9");
    cycle(1, 0, 0, 0, 0, 0, 0, "R5");
    cycle(0, 1, 0, 0, 0, 0, 0, "R6");
    cycle(0, 1, 0, 0, 0, 0, 0, "R6");
    cycle(0, 1, 0, 0, 0, 0, 0, "R9");

    // R8: eight nested calls, the last one overflows
    for (int n = 0; n < 8; n++)
      cycle(1, 0, 1, 10 + n % 6, 32'h8000_0000 + 32'(n), 20, 26, "R8");
    cycle(0, 0, 0, 0, 0, 10, 26, "R8");
    cycle(1, 0, 0, 0, 0, 0, 0, "R8");

    // random walk
    for (int n = 0; n < 4000; n++) begin
      int unsigned sel;
      logic c, r, we;
      sel = $urandom % 10;
      c   = (sel < 2) || (sel == 9);
      r   = (sel >= 2 && sel < 4) || (sel == 9);
      we  = ($urandom % 10) < 6;
      cycle(c, r, we, int'($urandom % 32), $urandom,
            int'($urandom % 32), int'($urandom % 32), "R12");
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule